// File: doc/BRIEF.md
# Rate-smoothing elastic store serial port

This block sits between a framing engine and an external bit-serial port that carries only a clock and a data line in each direction, with no framing or byte-alignment signals. In the receive direction the framing engine hands over payload bytes in bursts. There is a gap once every superframe, where every 69th frame is a sync slot that carries no payload. The block stores these bytes in a byte FIFO. It then shifts them out most-significant bit first, at a constant bit rate, on a clock it generates itself. In the transmit direction the external device supplies the bit clock. The block samples serial data on that clock and hands complete bytes to the framing engine.

The output clock comes from a phase accumulator of `ACC_W` bits that runs on the system clock. Each accumulator carry toggles the output clock, so the bit rate is f_clk * rate / 2^(ACC_W+1). The rate word is captured once, right after reset, and is locked until the next reset. Output is held off until the FIFO is half full, so that jitter in the arrival of bytes is centred in the buffer. The external rate must stay roughly constant. A lasting mismatch between the write rate and the bit rate raises a sticky overflow flag or a sticky underflow flag.

Top module: `elastic_bit_port`

## Requirements
- R1: While rst_ni is low, and right after it rises, the outputs are as follows: rx_clk_o is 0, rx_data_o is 1, ovf_o is 0, udf_o is 0 and tx_valid_o is 0.
- R2: rate_i is captured at the first clk_i rising edge after rst_ni rises. Later changes of rate_i have no effect on the output until the next reset.
- R3: After start, a phase accumulator of ACC_W bits adds the captured rate on every clk_i edge. Each edge on which the addition carries out toggles rx_clk_o.
- R4: rx_data_o changes only on the clk_i edge on which rx_clk_o rises. Each byte is sent most-significant bit first, eight bits per byte, with no gap between bytes.
- R5: Until the FIFO has held at least DEPTH/2 bytes at a clk_i edge, the accumulator is frozen, rx_clk_o stays 0 and rx_data_o stays 1. After that the output runs until the next reset.
- R6: Bytes written with wr_valid_i come out in write order. Bursts and gaps in writing cause no loss as long as the average write rate matches the bit rate.
- R7: If a new byte is needed at a rising edge of rx_clk_o while the FIFO is empty, udf_o is set and stays set until reset, and eight 1 bits are sent in place of the missing byte.
- R8: A write while the FIFO holds DEPTH bytes is dropped, and ovf_o is set and stays set until reset.
- R9: tx_data_i is sampled at each rising edge of tx_clk_i, after a synchroniser of SYNC stages. Bits are assembled most-significant bit first. After every eighth bit, tx_byte_o carries the byte and tx_valid_o is high for one clk_i cycle. The bit count starts at zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | ACC_W | Accumulator increment, captured after reset |
| wr_byte_i | input | 8 | Payload byte from the framing engine |
| wr_valid_i | input | 1 | Write strobe for wr_byte_i |
| rx_clk_o | output | 1 | Generated bit clock |
| rx_data_o | output | 1 | Serial data, launched on the rising edge of rx_clk_o |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |
| tx_clk_i | input | 1 | External bit clock for the transmit direction |
| tx_data_i | input | 1 | Serial data, sampled on the rising edge of tx_clk_i |
| tx_byte_o | output | 8 | Assembled byte |
| tx_valid_o | output | 1 | One-cycle strobe for tx_byte_o |

## Verification
A wrong accumulator value or a wrongly captured rate shows up at rx_clk_o as a toggle on the wrong clk_i cycle. Because the model is compared on every clock, this is caught within one accumulator period. A wrong FIFO pointer or a wrong shift count corrupts rx_data_o on the next rising edge of rx_clk_o, which means within one bit time. A wrong start threshold moves the first edge of rx_clk_o, which is caught in the cycle where the edge should or should not have appeared. A wrong full or empty condition makes ovf_o or udf_o differ in the very cycle of the offending write or read.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ebp_fifo.sv
module ebp_fifo import ebp_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  byte_t         wdata_i,
  input  logic          rd_i,
  output byte_t         rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  byte_t          mem_q [DEPTH];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  cnt_q;
  logic           push, pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push    = wr_i & ~full_o;
  assign pop     = rd_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ebp_nco.sv
module ebp_nco #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ACC_W-1:0] rate_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, rate_i};
  assign tick_o = run_i & sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (run_i) acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ebp_rx_shift.sv
module ebp_rx_shift import ebp_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  empty_i,
  input  byte_t rdata_i,
  output logic  rd_o,
  output logic  bit_clk_o,
  output logic  bit_o,
  output logic  udf_o
);
  localparam int BC_W = $clog2(BYTE_W);

  logic            phase_q, data_q, udf_q;
  byte_t           sh_q;
  logic [BC_W-1:0] cnt_q;
  logic            rise, need;

  assign rise = tick_i & ~phase_q;
  assign need = rise & (cnt_q == '0);
  assign rd_o = need & ~empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      data_q  <= 1'b1;
      udf_q   <= 1'b0;
      sh_q    <= '1;
      cnt_q   <= '0;
    end else begin
      if (tick_i) phase_q <= ~phase_q;
      if (need) begin
        cnt_q <= BC_W'(BYTE_W - 1);
        if (!empty_i) begin
          data_q <= rdata_i[BYTE_W-1];
          sh_q   <= {rdata_i[BYTE_W-2:0], 1'b1};
        end else begin
          udf_q  <= 1'b1;       // send a byte of ones
          data_q <= 1'b1;
          sh_q   <= '1;
        end
      end else if (rise) begin
        data_q <= sh_q[BYTE_W-1];
        sh_q   <= {sh_q[BYTE_W-2:0], 1'b1};
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign bit_clk_o = phase_q;
  assign bit_o     = data_q;
  assign udf_o     = udf_q;
endmodule

// File: rtl/ebp_tx_deser.sv
module ebp_tx_deser import ebp_pkg::*; #(
  parameter int SYNC = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ser_clk_i,
  input  logic  ser_data_i,
  output byte_t byte_o,
  output logic  valid_o
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [SYNC:0]   clk_sync_q;
  logic [SYNC-1:0] dat_sync_q;
  logic [BC_W-1:0] cnt_q;
  byte_t           sh_q, byte_q;
  logic            valid_q, rise, bit_in;

  assign rise   = clk_sync_q[SYNC-1] & ~clk_sync_q[SYNC];
  assign bit_in = dat_sync_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sync_q <= '0;
      dat_sync_q <= '0;
      cnt_q      <= '0;
      sh_q       <= '0;
      byte_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      clk_sync_q <= {clk_sync_q[SYNC-1:0], ser_clk_i};
      dat_sync_q <= {dat_sync_q[SYNC-2:0], ser_data_i};
      valid_q    <= 1'b0;
      if (rise) begin
        sh_q  <= {sh_q[BYTE_W-2:0], bit_in};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == BC_W'(BYTE_W - 1)) begin
          byte_q  <= {sh_q[BYTE_W-2:0], bit_in};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/elastic_bit_port.sv
module elastic_bit_port import ebp_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int ACC_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] rate_i,
  input  byte_t            wr_byte_i,
  input  logic             wr_valid_i,
  output logic             rx_clk_o,
  output logic             rx_data_o,
  output logic             ovf_o,
  output logic             udf_o,
  input  logic             tx_clk_i,
  input  logic             tx_data_i,
  output byte_t            tx_byte_o,
  output logic             tx_valid_o
);
  localparam int CW     = $clog2(DEPTH) + 1;
  localparam int THRESH = DEPTH / 2;

  logic [ACC_W-1:0] rate_q;
  logic             cap_q, started_q, ovf_q;
  logic             tick, fifo_rd, fifo_full, fifo_empty;
  byte_t            fifo_rdata;
  logic [CW-1:0]    fifo_cnt;

  // rate locked at first edge after reset; start once half full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q    <= '0;
      cap_q     <= 1'b0;
      started_q <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (!cap_q) begin
        rate_q <= rate_i;
        cap_q  <= 1'b1;
      end
      if (fifo_cnt >= CW'(THRESH)) started_q <= 1'b1;
      if (wr_valid_i && fifo_full)  ovf_q     <= 1'b1;
    end
  end

  ebp_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .wr_i(wr_valid_i), .wdata_i(wr_byte_i),
    .rd_i(fifo_rd), .rdata_o(fifo_rdata),
    .count_o(fifo_cnt), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  ebp_nco #(.ACC_W(ACC_W)) nco_i (
    .clk_i, .rst_ni, .run_i(started_q), .rate_i(rate_q), .tick_o(tick)
  );

  ebp_rx_shift shift_i (
    .clk_i, .rst_ni, .tick_i(tick), .empty_i(fifo_empty), .rdata_i(fifo_rdata),
    .rd_o(fifo_rd), .bit_clk_o(rx_clk_o), .bit_o(rx_data_o), .udf_o(udf_o)
  );

  ebp_tx_deser #(.SYNC(SYNC)) deser_i (
    .clk_i, .rst_ni, .ser_clk_i(tx_clk_i), .ser_data_i(tx_data_i),
    .byte_o(tx_byte_o), .valid_o(tx_valid_o)
  );

  assign ovf_o = ovf_q;
endmodule

// File: rtl/elastic_bit_port_chk.sv
module elastic_bit_port_chk #(
  parameter int DEPTH = 16,
  parameter int ACC_W = 16,
  parameter int CW    = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_clk_o,
  input logic             rx_data_o,
  input logic             ovf_o,
  input logic             udf_o,
  input logic             tx_valid_o,
  input logic             cap_q,
  input logic [ACC_W-1:0] rate_q,
  input logic             started_q,
  input logic [CW-1:0]    fifo_cnt
);
  AST_RATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |=> $stable(rate_q)); // R2

  AST_DATA_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> $rose(rx_clk_o)); // R4

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (!rx_clk_o && rx_data_o)); // R5

  AST_STAY_STARTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q); // R5

  AST_UDF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> udf_o); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH)); // R8

  AST_TX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o); // R9
endmodule

bind elastic_bit_port elastic_bit_port_chk #(.DEPTH(DEPTH), .ACC_W(ACC_W), .CW(CW)) chk_i (
  .clk_i, .rst_ni, .rx_clk_o, .rx_data_o, .ovf_o, .udf_o, .tx_valid_o,
  .cap_q, .rate_q, .started_q, .fifo_cnt
);

// File: tb/elastic_bit_port_tb_top.sv
`timescale 1ns/1ps
module elastic_bit_port_tb_top;
  localparam int DEPTH = 16;
  localparam int ACC_W = 16;
  localparam longint MOD = 64'd1 << ACC_W;

  logic clk = 0, rst_n = 0;
  logic [ACC_W-1:0] rate = '0;
  logic [7:0] wr_byte = '0;
  logic wr_valid = 0, tx_clk = 0, tx_data = 0;
  logic rx_clk, rx_data, ovf, udf, tx_valid;
  logic [7:0] tx_byte;

  always #5 clk = ~clk;

  elastic_bit_port #(.DEPTH(DEPTH), .ACC_W(ACC_W), .SYNC(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate), .wr_byte_i(wr_byte), .wr_valid_i(wr_valid),
    .rx_clk_o(rx_clk), .rx_data_o(rx_data), .ovf_o(ovf), .udf_o(udf),
    .tx_clk_i(tx_clk), .tx_data_i(tx_data), .tx_byte_o(tx_byte), .tx_valid_o(tx_valid)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  longint m_acc, m_rate;
  bit m_phase, m_data, m_started, m_ovf, m_udf, m_cap;
  int m_cnt, m_sh;
  byte unsigned m_q[$];
  byte unsigned got[$];

  task automatic chk(bit ok, string t, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_rate = 0; m_phase = 0; m_data = 1; m_started = 0;
      m_ovf = 0; m_udf = 0; m_cap = 0; m_cnt = 0; m_sh = 255; m_q.delete();
    end else begin
      int pre;
      bit tick, rise;
      pre  = m_q.size();
      tick = m_started && (m_acc + m_rate >= MOD);
      rise = tick && !m_phase;
      if (m_started) m_acc = (m_acc + m_rate) % MOD;
      if (rise) begin
        if (m_cnt == 0) begin
          m_cnt = 7;
          if (pre > 0) begin
            int b;
            b = m_q.pop_front();
            m_data = b[7]; m_sh = (b << 1) & 255;
          end else begin
            m_udf = 1; m_data = 1; m_sh = 255;
          end
        end else begin
          m_data = m_sh[7]; m_sh = (m_sh << 1) & 255; m_cnt--;
        end
      end
      if (wr_valid) begin
        if (pre == DEPTH) m_ovf = 1;
        else m_q.push_back(wr_byte);
      end
      if (pre >= DEPTH / 2) m_started = 1;
      if (tick) m_phase = !m_phase;
      if (!m_cap) begin m_rate = rate; m_cap = 1; end
    end
  end

  // compare on every cycle away from the active edge
  always @(negedge clk) begin
    chk({rx_clk, rx_data, ovf, udf} == {m_phase, m_data, m_ovf, m_udf},
        rst_n ? tag : "R1", {rx_clk, rx_data, ovf, udf}, {m_phase, m_data, m_ovf, m_udf});
    if (!rst_n) chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    if (tx_valid) got.push_back(tx_byte);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic push(byte unsigned b);
    wr_byte = b; wr_valid = 1; step(); wr_valid = 0;
  endtask

  task automatic send_tx(byte unsigned b);
    for (int i = 7; i >= 0; i--) begin
      tx_clk = 0; tx_data = b[i]; step(4);
      tx_clk = 1; step(4);
    end
  endtask

  initial begin
    byte unsigned tx_exp[4] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
    int rises;
    bit prev;
    rate = 16'd16384;
    step(3);
    chk(!rx_clk && rx_data && !ovf && !udf, "R1 reset outputs",
        {rx_clk, rx_data, ovf, udf}, 4'b0100);
    rst_n = 1; tag = "R5";
    for (int i = 0; i < 7; i++) push(8'(i * 37 + 5));
    step(30);
    chk(!rx_clk && rx_data, "R5 held off below threshold", {rx_clk, rx_data}, 2'b01);
    push(8'hC3);
    tag = "R6";
    for (int k = 0; k < 48; k++) begin
      if (k % 6 == 5) step(64);
      else if (k % 6 == 0 && k > 0) begin push(8'(k)); push(8'(k + 100)); step(62); end
      else begin push(8'(k * 11)); step(63); end
    end
    chk(!ovf && !udf, "R6 no flags on smoothed gaps", {ovf, udf}, 0);
    tag = "R7";
    step(1400);
    chk(udf == 1, "R7 underflow sticky", udf, 1);
    for (int i = 0; i < 4; i++) begin
      step(16);
      chk(rx_data == 1, "R7 ones while empty", rx_data, 1);
    end

    rst_n = 0; step(2);
    chk(!rx_clk && rx_data && !ovf && !udf, "R1 second reset",
        {rx_clk, rx_data, ovf, udf}, 4'b0100);
    rate = 16'd10923; step();
    rst_n = 1; tag = "R3";
    for (int i = 0; i < 8; i++) push(8'(8'h80 + i));
    for (int k = 0; k < 30; k++) begin
      push(8'(k * 7 + 1)); step(95);
      if (k == 10) begin
        tag = "R2"; rate = 16'd60000;
        rises = 0; prev = rx_clk;
        for (int j = 0; j < 240; j++) begin
          step();
          if (rx_clk && !prev) rises++;
          prev = rx_clk;
        end
        chk(rises >= 18 && rises <= 22, "R2 rate held after change", rises, 20);
        k = k + 2;
      end
    end

    rst_n = 0; step(2);
    rate = 16'd1; step();
    rst_n = 1; tag = "R8";
    for (int i = 0; i < 20; i++) push(8'(i));
    chk(ovf == 1, "R8 overflow sticky", ovf, 1);
    got.delete();
    tag = "R9";
    foreach (tx_exp[i]) send_tx(tx_exp[i]);
    step(10);
    chk(got.size() == 4, "R9 byte count", got.size(), 4);
    foreach (tx_exp[i])
      if (i < got.size()) chk(got[i] == tx_exp[i], "R9 tx byte", got[i], tx_exp[i]);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule